// File: doc/BRIEF.md
# Memory Copy and Verify Controller

This block runs a self-contained copy-and-check sequence between two single-port synchronous memories that sit outside it. A start pulse launches the sequence. The controller first loads every source word with a known pattern. It then copies each word into the destination and reads both memories back to compare them word for word.

Every access to the destination is held back until a destination-ready input is high. This lets the surrounding system decide when the second memory may be used. A built-in elapsed-cycle counter runs only during the copy and compare work, so the pattern load does not affect the measured figure.

When the traversal ends, a one-cycle done pulse is given and busy drops. A sticky error flag and the first failing address report whether the two memories agreed. Both memories are expected to return read data one cycle after the address is presented.

Top module: `mcv_top`

## Requirements
- R1: While reset is low and in the first cycle after it, busy, done and err are 0, cycles is 0, and neither src_we nor dst_en is asserted.
- R2: A start pulse while idle begins a fill of DEPTH consecutive cycles. The fill writes source address a with data (a XOR 0xA5) for a = 0 up to DEPTH-1. The destination is not accessed during the fill, and src_we is never high outside the fill.
- R3: After the copy phase, every destination word holds the word read from the same source address (dst[a] == src[a] for all a, unless a write was corrupted on its way into the memory).
- R4: dst_en is high only in cycles where dst_rdy is high. Each copy write waits for dst_rdy, and each compare-side destination read also waits for dst_rdy.
- R5: The compare phase visits every address in ascending order. On the first mismatch, err goes to 1 and err_addr takes that address. err stays set and err_addr keeps the lowest failing address until the next start, and the traversal runs to the end even after an error.
- R6: Completion is signalled by done high for exactly one cycle, with busy low in that cycle. busy is high in every cycle from the one after the accepted start until done.
- R7: cycles counts exactly the cycles spent copying and comparing. With dst_rdy held high this is 7*DEPTH (three cycles per copied word and four per compared word). Each cycle spent waiting on dst_rdy adds one. The fill is not counted. cycles is cleared by an accepted start and holds its value after done.
- R8: A start pulse while busy is ignored: the running sequence and its timing are unchanged, and only one done pulse results.
- R9: An accepted start clears err and err_addr, so a clean run after a failing one ends with err at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a sequence when idle |
| dst_rdy | input | 1 | Destination may be accessed this cycle |
| src_we | output | 1 | Source write enable |
| src_addr | output | AW | Source address (reads every cycle) |
| src_wdata | output | DW | Source write data |
| src_rdata | input | DW | Source read data, one cycle after address |
| dst_en | output | 1 | Destination access enable (read or write) |
| dst_we | output | 1 | Destination write enable (with dst_en) |
| dst_addr | output | AW | Destination address |
| dst_wdata | output | DW | Destination write data |
| dst_rdata | input | DW | Destination read data, one cycle after an enabled read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky mismatch flag |
| err_addr | output | AW | Lowest address that mismatched |
| cycles | output | CW | Elapsed copy-and-compare cycles |

## Verification
The bench goes after the ready handshake under random and long bursty stalls. If the controller wrote or read the destination early, or failed to hold its place while waiting, the cycle count would drift from the model and the copied contents would be wrong. Corrupted destination writes are placed at the first address, at a middle pair of addresses, and at the last address. These catch a design that latches a later failing address, stops the traversal early, or skips the final compare. A start pulse mid-run and a clean run after a failing one expose a design that restarts while busy or keeps a stale error.

// File: rtl/mcv_pkg.sv
// Shared types for the memory copy and verify controller.
// Assumes: one sequencer state machine and one timer state machine use these.
package mcv_pkg;

    // Sequencer states: idle, fill, copy (read, capture, write), verify (read, capture, wait, compare)
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FILL,
        ST_CRD,
        ST_CCAP,
        ST_CWR,
        ST_VRD,
        ST_VCAP,
        ST_VWAIT,
        ST_VCMP
    } mcv_state_t;

    // Elapsed-cycle timer states
    typedef enum logic {
        TM_STOP,
        TM_RUN
    } mcv_tm_state_t;

endpackage

// File: rtl/mcv_filler.sv
// Pattern filler: while enabled, walks an index from 0 upward and issues one
// source write per cycle with data equal to the index XOR a fixed constant.
// Assumes: enable stays high for exactly DEPTH cycles; the index returns to 0
// whenever enable is low.
module mcv_filler #(
    parameter int              AW      = 4,
    parameter int              DW      = 8,
    parameter logic [DW-1:0]   PATTERN = 8'hA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data,
    output logic          last
);

    logic [AW-1:0] idx;

    // Index counter: advances while filling, parks at zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (en) begin
            idx <= idx + 1'b1;
        end else begin
            idx <= '0;
        end
    end

    // Write port drive: pattern derived from the current index
    always_comb begin
        we   = en;
        addr = idx;
        data = DW'(idx) ^ PATTERN;
        last = en && (&idx);
    end

endmodule

// File: rtl/mcv_src_mux.sv
// Source-port selector: hands the source memory port either to the filler or
// to the copy/compare sequencer.
// Assumes: the sequencer never writes the source; only the filler does.
module mcv_src_mux #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_fill,
    input  logic          fill_we,
    input  logic [AW-1:0] fill_addr,
    input  logic [DW-1:0] fill_data,
    input  logic [AW-1:0] seq_addr,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);

    // Port selection between filler and sequencer
    always_comb begin
        if (sel_fill) begin
            mem_we    = fill_we;
            mem_addr  = fill_addr;
            mem_wdata = fill_data;
        end else begin
            mem_we    = 1'b0;
            mem_addr  = seq_addr;
            mem_wdata = '0;
        end
    end

    // R2
    fill_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> sel_fill);

endmodule

// File: rtl/mcv_timer.sv
// Elapsed-cycle timer: a counter plus a two-state run/stop machine.
// clr zeroes the count and stops it; go starts counting on the next cycle;
// halt stops it after counting the current cycle.
// Assumes: go and halt are never high together.
module mcv_timer #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          go,
    input  logic          halt,
    output logic [CW-1:0] count
);
    import mcv_pkg::*;

    mcv_tm_state_t tst;

    // Run/stop control
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tst <= TM_STOP;
        end else if (go) begin
            tst <= TM_RUN;
        end else if (halt) begin
            tst <= TM_STOP;
        end
    end

    // Counter: increments once per running cycle
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (tst == TM_RUN) begin
            count <= count + 1'b1;
        end
    end

    // R7
    frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tst == TM_STOP && !clr && !go) |=> $stable(count));

endmodule

// File: rtl/mcv_seq.sv
// Copy/compare sequencer. After a start pulse it runs the fill (carried out by
// the filler), then copies each source word into the destination, then reads
// both memories back and compares them. Destination accesses wait for dst_rdy.
// Assumes: both memories return read data one cycle after the address.
module mcv_seq #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dst_rdy,
    output logic          fill_en,
    input  logic          fill_last,
    output logic [AW-1:0] src_addr,
    input  logic [DW-1:0] src_rdata,
    output logic          dst_en,
    output logic          dst_we,
    output logic [AW-1:0] dst_addr,
    output logic [DW-1:0] dst_wdata,
    input  logic [DW-1:0] dst_rdata,
    output logic          tm_clr,
    output logic          tm_go,
    output logic          tm_halt,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] err_addr
);
    import mcv_pkg::*;

    mcv_state_t    st, st_nx;
    logic [AW-1:0] idx;
    logic [DW-1:0] hold;
    logic          last_idx;
    logic          accept;

    assign last_idx = &idx;
    assign accept   = (st == ST_IDLE) && start;

    // Next-state selection
    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:  if (start) st_nx = ST_FILL;
            ST_FILL:  if (fill_last) st_nx = ST_CRD;
            ST_CRD:   st_nx = ST_CCAP;
            ST_CCAP:  st_nx = ST_CWR;
            ST_CWR:   if (dst_rdy) st_nx = last_idx ? ST_VRD : ST_CRD;
            ST_VRD:   st_nx = ST_VCAP;
            ST_VCAP:  st_nx = ST_VWAIT;
            ST_VWAIT: if (dst_rdy) st_nx = ST_VCMP;
            ST_VCMP:  st_nx = last_idx ? ST_IDLE : ST_VRD;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Word index: advances after each destination write and each compare
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            idx <= '0;
        end else if ((st == ST_CWR && dst_rdy) || st == ST_VCMP) begin
            idx <= idx + 1'b1;
        end
    end

    // Holding register for the source word one cycle after its address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (st == ST_CCAP || st == ST_VCAP) begin
            hold <= src_rdata;
        end
    end

    // Sticky mismatch flag and first failing address
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            err      <= 1'b0;
            err_addr <= '0;
        end else if (st == ST_VCMP && hold != dst_rdata && !err) begin
            err      <= 1'b1;
            err_addr <= idx;
        end
    end

    // Completion pulse, raised as the final compare retires
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (st == ST_VCMP) && last_idx;
    end

    // Port and timer control decode
    always_comb begin
        fill_en   = (st == ST_FILL);
        src_addr  = idx;
        dst_addr  = idx;
        dst_wdata = hold;
        dst_we    = (st == ST_CWR) && dst_rdy;
        dst_en    = ((st == ST_CWR) || (st == ST_VWAIT)) && dst_rdy;
        tm_clr    = accept;
        tm_go     = (st == ST_FILL) && fill_last;
        tm_halt   = (st == ST_VCMP) && last_idx;
        busy      = (st != ST_IDLE);
    end

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);

    // R2
    fill_no_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !dst_en);

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st != ST_VCMP) |=> busy);

endmodule

// File: rtl/mcv_top.sv
// Memory copy and verify controller top. Ties the filler, the source-port
// selector, the sequencer and the elapsed-cycle timer together. Both memories
// are outside the block and attach through the src_* and dst_* ports.
// Assumes: synchronous memories with one cycle of read latency.
module mcv_top #(
    parameter int            AW      = 4,
    parameter int            DW      = 8,
    parameter int            CW      = 32,
    parameter logic [DW-1:0] PATTERN = 8'hA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dst_rdy,
    output logic          src_we,
    output logic [AW-1:0] src_addr,
    output logic [DW-1:0] src_wdata,
    input  logic [DW-1:0] src_rdata,
    output logic          dst_en,
    output logic          dst_we,
    output logic [AW-1:0] dst_addr,
    output logic [DW-1:0] dst_wdata,
    input  logic [DW-1:0] dst_rdata,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] err_addr,
    output logic [CW-1:0] cycles
);

    logic          fill_en, fill_we, fill_last;
    logic [AW-1:0] fill_addr, seq_src_addr;
    logic [DW-1:0] fill_data;
    logic          tm_clr, tm_go, tm_halt;

    mcv_filler #(.AW(AW), .DW(DW), .PATTERN(PATTERN)) u_filler (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (fill_en),
        .we    (fill_we),
        .addr  (fill_addr),
        .data  (fill_data),
        .last  (fill_last)
    );

    mcv_src_mux #(.AW(AW), .DW(DW)) u_src_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_fill  (fill_en),
        .fill_we   (fill_we),
        .fill_addr (fill_addr),
        .fill_data (fill_data),
        .seq_addr  (seq_src_addr),
        .mem_we    (src_we),
        .mem_addr  (src_addr),
        .mem_wdata (src_wdata)
    );

    mcv_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dst_rdy   (dst_rdy),
        .fill_en   (fill_en),
        .fill_last (fill_last),
        .src_addr  (seq_src_addr),
        .src_rdata (src_rdata),
        .dst_en    (dst_en),
        .dst_we    (dst_we),
        .dst_addr  (dst_addr),
        .dst_wdata (dst_wdata),
        .dst_rdata (dst_rdata),
        .tm_clr    (tm_clr),
        .tm_go     (tm_go),
        .tm_halt   (tm_halt),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .err_addr  (err_addr)
    );

    mcv_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tm_clr),
        .go    (tm_go),
        .halt  (tm_halt),
        .count (cycles)
    );

    // R4
    dst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_en |-> dst_rdy);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    cycles_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(cycles));

endmodule

// File: tb/mcv_top_bench.sv
// Bench: behavioural memories, a cycle-level reference model and per-clock
// comparison of the controller's status outputs.
module mcv_top_bench;

    localparam int            CLK_PERIOD = 10;
    localparam int            AW         = 4;
    localparam int            DW         = 8;
    localparam int            CW         = 32;
    localparam int            DEPTH      = 1 << AW;
    localparam logic [DW-1:0] PAT        = 8'hA5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          dst_rdy = 1'b1;
    logic          src_we, dst_en, dst_we;
    logic [AW-1:0] src_addr, dst_addr, err_addr;
    logic [DW-1:0] src_wdata, dst_wdata;
    logic [DW-1:0] src_rdata = '0;
    logic [DW-1:0] dst_rdata = '0;
    logic          busy, done, err;
    logic [CW-1:0] cycles;

    int checks = 0;
    int failures = 0;
    int done_seen = 0;
    bit chk_on = 0;
    int rdy_mode = 0;
    int tick = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [DW-1:0] src_mem [DEPTH];
    logic [DW-1:0] dst_mem [DEPTH];
    int  fault_a0 = -1;
    int  fault_a1 = -1;
    localparam logic [DW-1:0] FMASK = 8'h10;

    // reference model state
    int     m_phase = 0;
    int     m_k = 0;
    int     m_step = 0;
    bit     m_done = 0;
    bit     m_err = 0;
    int     m_eaddr = 0;
    longint m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcv_top #(.AW(AW), .DW(DW), .CW(CW), .PATTERN(PAT)) u_mcv_top (
        .clk(clk), .rst_n(rst_n), .start(start), .dst_rdy(dst_rdy),
        .src_we(src_we), .src_addr(src_addr), .src_wdata(src_wdata), .src_rdata(src_rdata),
        .dst_en(dst_en), .dst_we(dst_we), .dst_addr(dst_addr), .dst_wdata(dst_wdata),
        .dst_rdata(dst_rdata), .busy(busy), .done(done), .err(err),
        .err_addr(err_addr), .cycles(cycles)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural memories; corrupted destination writes at chosen addresses
    always @(posedge clk) begin
        if (src_we) src_mem[src_addr] <= src_wdata;
        src_rdata <= src_mem[src_addr];
        if (dst_en) begin
            if (dst_we) begin
                if (int'(dst_addr) == fault_a0 || int'(dst_addr) == fault_a1)
                    dst_mem[dst_addr] <= dst_wdata ^ FMASK;
                else
                    dst_mem[dst_addr] <= dst_wdata;
            end else begin
                dst_rdata <= dst_mem[dst_addr];
            end
        end
    end

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_k = 0; m_step = 0; m_done = 0;
            m_err = 0; m_eaddr = 0; m_cnt = 0;
        end else begin
            m_done = 0;
            case (m_phase)
                0: if (start) begin
                    m_phase = 1; m_k = 0; m_err = 0; m_eaddr = 0; m_cnt = 0;
                end
                1: if (m_k == DEPTH-1) begin
                    m_phase = 2; m_k = 0; m_step = 0;
                end else m_k++;
                2: begin
                    m_cnt++;
                    if (m_step < 2) m_step++;
                    else if (dst_rdy) begin
                        m_step = 0;
                        if (m_k == DEPTH-1) begin m_phase = 3; m_k = 0; end
                        else m_k++;
                    end
                end
                default: begin
                    m_cnt++;
                    if (m_step < 2) m_step++;
                    else if (m_step == 2) begin
                        if (dst_rdy) m_step = 3;
                    end else begin
                        if (src_mem[m_k] !== dst_mem[m_k] && !m_err) begin
                            m_err = 1; m_eaddr = m_k;
                        end
                        m_step = 0;
                        if (m_k == DEPTH-1) begin m_phase = 0; m_done = 1; end
                        else m_k++;
                    end
                end
            endcase
        end
    end

    // ready driver, just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            tick++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (rdy_mode)
                0: dst_rdy = 1'b1;
                1: dst_rdy = lfsr[0] | lfsr[3];
                default: dst_rdy = (tick % 11) < 4;
            endcase
        end
    end

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            check(busy === (m_phase != 0), "R6", "busy", busy, m_phase != 0);
            check(done === m_done, "R6", "done", done, m_done);
            check(err === m_err, "R5", "err", err, m_err);
            check(err_addr === AW'(m_eaddr), "R5", "err_addr", err_addr, m_eaddr);
            check(cycles === CW'(m_cnt), "R7", "cycles", cycles, m_cnt);
            check(!(dst_en && !dst_rdy), "R4", "dst_en without ready", dst_en, 0);
            check(!(src_we && m_phase != 1), "R2", "src_we outside fill", src_we, 0);
            check(!(dst_en && m_phase == 1), "R2", "dst access in fill", dst_en, 0);
            if (done === 1'b1) done_seen++;
        end
    end

    task automatic run_op(input int mode, input int fa0, input int fa1, input bit mid_start);
        rdy_mode = mode;
        fault_a0 = fa0;
        fault_a1 = fa1;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        if (mid_start) begin
            repeat (40) @(posedge clk);
            #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_mems(input string tag);
        for (int a = 0; a < DEPTH; a++) begin
            logic [DW-1:0] e;
            e = DW'(a) ^ PAT;
            check(src_mem[a] === e, "R2", {tag, " src word"}, src_mem[a], e);
            if (a == fault_a0 || a == fault_a1) e = e ^ FMASK;
            check(dst_mem[a] === e, "R3", {tag, " dst word"}, dst_mem[a], e);
        end
    endtask

    // watchdog: an expired run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int d0;
        logic [CW-1:0] held;
        for (int a = 0; a < DEPTH; a++) begin
            src_mem[a] = '0;
            dst_mem[a] = '0;
        end
        repeat (2) @(posedge clk);
        chk_on = 1;
        @(negedge clk);
        // R1: reset state
        check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1", "status in reset", busy, 0);
        check(cycles === '0, "R1", "cycles in reset", cycles, 0);
        check(src_we === 1'b0 && dst_en === 1'b0, "R1", "ports in reset", src_we, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && cycles === '0, "R1", "after reset", busy, 0);

        // clean run, ready always high: R7 exact count
        run_op(0, -1, -1, 0);
        check(cycles == CW'(7*DEPTH), "R7", "unstalled count", cycles, 7*DEPTH);
        check(err === 1'b0, "R5", "clean err", err, 0);
        check_mems("run1");
        held = cycles;
        repeat (5) @(negedge clk);
        check(cycles === held, "R7", "held after done", cycles, held);
        check(done === 1'b0 && busy === 1'b0, "R6", "quiet after done", done, 0);

        // random stalls: R4 gating, R7 stall accounting
        run_op(1, -1, -1, 0);
        check(cycles > CW'(7*DEPTH), "R7", "stalled count grows", cycles, 7*DEPTH+1);
        check(err === 1'b0, "R3", "stalled copy clean", err, 0);
        check_mems("run2");

        // two faults with a start while busy: R5 first address, R8 ignored start
        d0 = done_seen;
        run_op(0, 5, 11, 1);
        check(err === 1'b1, "R5", "err set", err, 1);
        check(err_addr === AW'(5), "R5", "first failing address", err_addr, 5);
        check(cycles == CW'(7*DEPTH), "R5", "full traversal after error", cycles, 7*DEPTH);
        repeat (3) @(negedge clk);
        check(done_seen - d0 == 1, "R8", "single done", done_seen - d0, 1);
        check(err === 1'b1 && err_addr === AW'(5), "R5", "sticky while idle", err_addr, 5);

        // bursty ready, fault at last address
        run_op(2, DEPTH-1, -1, 0);
        check(err === 1'b1 && err_addr === AW'(DEPTH-1), "R5", "last address fault", err_addr, DEPTH-1);
        check_mems("run4");

        // fault at address 0
        run_op(0, 0, -1, 0);
        check(err === 1'b1 && err_addr === AW'(0), "R5", "address zero fault", err_addr, 0);

        // R9: clean run clears the flag
        run_op(1, -1, -1, 0);
        check(err === 1'b0 && err_addr === AW'(0), "R9", "error cleared by start", err, 0);
        check_mems("run6");

        chk_on = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule